// File: doc/BRIEF.md
# Load/store address generation unit

This unit sits between instruction decode and the memory port of a simple in-order core. It handles single-data-transfer instructions whose offset comes from a register. A strobe presents the 32-bit instruction word, the base register value, an offset that has already been through the shifter, and the current processor mode. One cycle later the unit presents the transfer address, the access size and direction, and a translate signal. It also flags encodings that are undefined, that trigger a breakpoint, or that are unpredictable.

While a transfer is outstanding, the unit holds the base write-back value. It releases that value only after the memory side reports completion without an abort. Byte loads are returned zero-extended. Post-indexed transfers with the write-back bit set are not given an extra write-back. Instead, they force an untranslated (user-privilege) access for the duration of that one transfer.

Top module: `ls_addr_gen`

## Requirements
- R1: A request is accepted only when `req_valid_i` is high, no transfer is outstanding, and instruction bits [27:25] equal 3'b011. Any other instruction produces no access, no flag and no write-back.
- R2: An accepted instruction with bit 4 set raises `undef_o` for one cycle, one cycle after the strobe, and issues no access. The exception is the breakpoint encoding of R3.
- R3: If instruction bits [27:20] equal 8'h7F, bit 4 is set and bits [19:0] equal 20'hFDEFE, then `bkpt_o` pulses instead of `undef_o`. No access is issued.
- R4: With bit 24 set (pre-indexed), the address is base plus offset when bit 23 is set, or base minus offset when it is clear. With bit 24 clear (post-indexed), the address is the unmodified base. All arithmetic is modulo 2^DATA_W.
- R5: The write-back value is base ± offset, with the sign chosen by bit 23. Write-back is requested for every post-indexed form. It is requested for pre-indexed forms only when bit 21 (W) is set.
- R6: `xlate_o` is low from the cycle after acceptance of a post-indexed transfer with W set until that transfer completes. At all other times it equals the OR of mode bits [1:0].
- R7: `wb_en_o` pulses for one cycle, in the cycle after `xfer_done_i`, only when `xfer_abort_i` is low and write-back was requested. An aborted transfer never writes back.
- R8: `acc_valid_o` pulses one cycle after acceptance. `acc_byte_o` follows bit 22 (1 = byte) and `acc_load_o` follows bit 20 (1 = load). Strobes arriving while a transfer is outstanding are ignored and leave the address unchanged.
- R9: A completed, unaborted load pulses `ld_valid_o`. For a byte access, `ld_data_o` is `rdata_i[7:0]` zero-extended; for a word access it is `rdata_i` unchanged.
- R10: For write-back forms, `unpred_o` is raised with the access in any of these cases:
  - base field [19:16] equals offset field [3:0];
  - base field equals destination field [15:12];
  - base field is 15;
  - offset field is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| base_i | input | DATA_W | Base register value |
| offset_i | input | DATA_W | Shifted offset value |
| mode_i | input | MODE_W | Current processor mode |
| xfer_done_i | input | 1 | Memory transfer finished |
| xfer_abort_i | input | 1 | Finished transfer aborted |
| rdata_i | input | DATA_W | Load data from memory |
| acc_valid_o | output | 1 | Access issue pulse |
| acc_addr_o | output | DATA_W | Access address |
| acc_byte_o | output | 1 | 1 = byte access |
| acc_load_o | output | 1 | 1 = load |
| xlate_o | output | 1 | Translate (privileged) signal |
| unpred_o | output | 1 | Unpredictable encoding flag |
| undef_o | output | 1 | Undefined instruction flag |
| bkpt_o | output | 1 | Breakpoint flag |
| wb_en_o | output | 1 | Base write-back enable |
| wb_val_o | output | DATA_W | Base write-back value |
| ld_valid_o | output | 1 | Load data valid |
| ld_data_o | output | DATA_W | Zero-extended load data |

## Verification
The bench builds the unit with DATA_W = 32, MODE_W = 5 and the shared-adder variant. The 32-bit width makes wrap-around at 2^32 reachable with directed bases near the top of the address space. The five mode bits let random modes exercise both translate levels, including modes whose upper bits are set while the low two bits are zero. Because register fields stay at 4 bits, random instructions frequently land on the register-15 and field-collision cases of the unpredictable check.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;
   localparam int unsigned REG_IDX_W = 4;
   localparam int unsigned INSTR_W   = 32;

   typedef struct packed {
      logic                 in_class;
      logic                 pre;
      logic                 up;
      logic                 byte_sz;
      logic                 wbit;
      logic                 load;
      logic                 undef;
      logic                 bkpt;
      logic [REG_IDX_W-1:0] rn;
      logic [REG_IDX_W-1:0] rd;
      logic [REG_IDX_W-1:0] rm;
   } lsag_dec_t;
endpackage

// File: rtl/ls_addr_gen_decode.sv
module ls_addr_gen_decode
   import ls_addr_gen_pkg::*;
#(
   parameter logic [19:0] BKPT_CODE = 20'hFDEFE
) (
   input  logic [INSTR_W-1:0] instr_i,
   output lsag_dec_t          dec_o
);
   logic class_hit;
   logic trap_bit;
   logic bkpt_hit;
   logic unused_cond;

   assign unused_cond = ^instr_i[31:28];
   assign class_hit   = (instr_i[27:25] == 3'b011);
   assign trap_bit    = instr_i[4];
   assign bkpt_hit    = class_hit && trap_bit && (instr_i[27:20] == 8'h7F)
                        && (instr_i[19:0] == BKPT_CODE);

   always_comb begin
      dec_o          = '0;
      dec_o.in_class = class_hit;
      dec_o.pre      = instr_i[24];
      dec_o.up       = instr_i[23];
      dec_o.byte_sz  = instr_i[22];
      dec_o.wbit     = instr_i[21];
      dec_o.load     = instr_i[20];
      dec_o.bkpt     = bkpt_hit;
      dec_o.undef    = class_hit && trap_bit && !bkpt_hit;
      dec_o.rn       = instr_i[19:16];
      dec_o.rd       = instr_i[15:12];
      dec_o.rm       = instr_i[3:0];
   end
endmodule

// File: rtl/ls_addr_gen_calc.sv
module ls_addr_gen_calc #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] offset_i,
   input  logic              up_i,
   input  logic              pre_i,
   output logic [DATA_W-1:0] addr_o,
   output logic [DATA_W-1:0] sum_o
);
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (ADDER_STYLE == 0) begin : g_shared
         logic [DATA_W-1:0] opnd;
         logic [DATA_W-1:0] cin;
         assign opnd  = up_i ? offset_i : ~offset_i;
         assign cin   = up_i ? '0 : ONE;
         assign sum_o = base_i + opnd + cin;
      end else begin : g_dual
         logic [DATA_W-1:0] s_add;
         logic [DATA_W-1:0] s_sub;
         assign s_add = base_i + offset_i;
         assign s_sub = base_i - offset_i;
         assign sum_o = up_i ? s_add : s_sub;
      end
   endgenerate

   assign addr_o = pre_i ? sum_o : base_i;
endmodule

// File: rtl/ls_addr_gen_hazard.sv
module ls_addr_gen_hazard
   import ls_addr_gen_pkg::*;
#(
   parameter int unsigned PC_IDX = 15
) (
   input  lsag_dec_t dec_i,
   output logic      wb_form_o,
   output logic      unpred_o
);
   localparam logic [REG_IDX_W-1:0] PC_REG = REG_IDX_W'(PC_IDX);

   logic [3:0] hit;

   assign wb_form_o = !dec_i.pre || dec_i.wbit;
   assign hit[0]    = (dec_i.rn == dec_i.rm);
   assign hit[1]    = (dec_i.rn == dec_i.rd);
   assign hit[2]    = (dec_i.rn == PC_REG);
   assign hit[3]    = (dec_i.rm == PC_REG);
   assign unpred_o  = wb_form_o && (|hit);
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import ls_addr_gen_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MODE_W      = 5,
   parameter int unsigned ADDER_STYLE = 0,
   parameter int unsigned PC_IDX      = 15,
   parameter logic [19:0] BKPT_CODE   = 20'hFDEFE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [31:0]        instr_i,
   input  logic [DATA_W-1:0]  base_i,
   input  logic [DATA_W-1:0]  offset_i,
   input  logic [MODE_W-1:0]  mode_i,
   input  logic               xfer_done_i,
   input  logic               xfer_abort_i,
   input  logic [DATA_W-1:0]  rdata_i,
   output logic               acc_valid_o,
   output logic [DATA_W-1:0]  acc_addr_o,
   output logic               acc_byte_o,
   output logic               acc_load_o,
   output logic               xlate_o,
   output logic               unpred_o,
   output logic               undef_o,
   output logic               bkpt_o,
   output logic               wb_en_o,
   output logic [DATA_W-1:0]  wb_val_o,
   output logic               ld_valid_o,
   output logic [DATA_W-1:0]  ld_data_o
);
   localparam int unsigned BYTE_W = 8;

   generate
      if (DATA_W < BYTE_W) begin : g_bad_width
         $error("ls_addr_gen: DATA_W must be at least 8");
      end
      if (MODE_W < 2) begin : g_bad_mode
         $error("ls_addr_gen: MODE_W must be at least 2");
      end
      if (ADDER_STYLE > 1) begin : g_bad_style
         $error("ls_addr_gen: ADDER_STYLE must be 0 or 1");
      end
      if (PC_IDX >= (1 << REG_IDX_W)) begin : g_bad_pc
         $error("ls_addr_gen: PC_IDX out of register range");
      end
   endgenerate

   lsag_dec_t         dec;
   logic [DATA_W-1:0] addr_nx;
   logic [DATA_W-1:0] sum_nx;
   logic              wb_form;
   logic              unpred_nx;
   logic              accept;
   logic              issue;
   logic              busy_q;
   logic              force_q;
   logic              wbreq_q;
   logic              unused_mode;

   ls_addr_gen_decode #(.BKPT_CODE(BKPT_CODE)) u_dec (
      .instr_i (instr_i),
      .dec_o   (dec)
   );

   ls_addr_gen_calc #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_calc (
      .base_i   (base_i),
      .offset_i (offset_i),
      .up_i     (dec.up),
      .pre_i    (dec.pre),
      .addr_o   (addr_nx),
      .sum_o    (sum_nx)
   );

   ls_addr_gen_hazard #(.PC_IDX(PC_IDX)) u_haz (
      .dec_i     (dec),
      .wb_form_o (wb_form),
      .unpred_o  (unpred_nx)
   );

   assign unused_mode = ^mode_i;
   assign accept      = req_valid_i && !busy_q && dec.in_class;
   assign issue       = accept && !dec.undef && !dec.bkpt;

   // flag and issue pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid_o <= 1'b0;
         undef_o     <= 1'b0;
         bkpt_o      <= 1'b0;
         unpred_o    <= 1'b0;
      end else begin
         acc_valid_o <= issue;
         undef_o     <= accept && dec.undef;
         bkpt_o      <= accept && dec.bkpt;
         unpred_o    <= issue && unpred_nx;
      end
   end

   // captured access descriptor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_addr_o <= '0;
         acc_byte_o <= 1'b0;
         acc_load_o <= 1'b0;
         wb_val_o   <= '0;
         wbreq_q    <= 1'b0;
      end else if (issue) begin
         acc_addr_o <= addr_nx;
         acc_byte_o <= dec.byte_sz;
         acc_load_o <= dec.load;
         wb_val_o   <= sum_nx;
         wbreq_q    <= wb_form;
      end
   end

   // outstanding transfer and completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         force_q    <= 1'b0;
         wb_en_o    <= 1'b0;
         ld_valid_o <= 1'b0;
         ld_data_o  <= '0;
      end else begin
         wb_en_o    <= 1'b0;
         ld_valid_o <= 1'b0;
         if (issue) begin
            busy_q  <= 1'b1;
            force_q <= !dec.pre && dec.wbit;
         end else if (busy_q && xfer_done_i) begin
            busy_q     <= 1'b0;
            force_q    <= 1'b0;
            wb_en_o    <= wbreq_q && !xfer_abort_i;
            ld_valid_o <= acc_load_o && !xfer_abort_i;
            if (acc_load_o && !xfer_abort_i) begin
               ld_data_o <= acc_byte_o
                  ? {{(DATA_W-BYTE_W){1'b0}}, rdata_i[BYTE_W-1:0]}
                  : rdata_i;
            end
         end
      end
   end

   assign xlate_o = force_q ? 1'b0 : (|mode_i[1:0]);
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              undef,
   input logic              bkpt,
   input logic              done,
   input logic              abort,
   input logic              wb_en,
   input logic              xlate,
   input logic [1:0]        mode_lo,
   input logic              ld_valid,
   input logic              acc_byte,
   input logic [DATA_W-1:0] ld_data
);
   AST_UNDEF_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> !acc_valid); // R2
   AST_BKPT_NOT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt |-> (!undef && !acc_valid)); // R3
   AST_WB_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(done && !abort)); // R7
   AST_ABORT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (done && abort) |=> !wb_en); // R7
   AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> !acc_valid); // R8
   AST_XLATE_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (xlate == (|mode_lo))); // R6
   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && acc_byte) |-> (ld_data[DATA_W-1:8] == '0)); // R9
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid_o),
   .undef     (undef_o),
   .bkpt      (bkpt_o),
   .done      (xfer_done_i),
   .abort     (xfer_abort_i),
   .wb_en     (wb_en_o),
   .xlate     (xlate_o),
   .mode_lo   (mode_i[1:0]),
   .ld_valid  (ld_valid_o),
   .acc_byte  (acc_byte_o),
   .ld_data   (ld_data_o)
);

// File: tb/ls_addr_gen_tb_top.sv
module ls_addr_gen_tb_top;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [31:0]   instr = '0;
   logic [DW-1:0] base = '0;
   logic [DW-1:0] offs = '0;
   logic [4:0]    mode = '0;
   logic          done = 1'b0;
   logic          abort = 1'b0;
   logic [DW-1:0] rdata = '0;
   logic          acc_valid, acc_byte, acc_load, xlate, unpred, undef, bkpt;
   logic          wb_en, ld_valid;
   logic [DW-1:0] acc_addr, wb_val, ld_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ls_addr_gen #(.DATA_W(DW), .MODE_W(5), .ADDER_STYLE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .instr_i(instr),
      .base_i(base), .offset_i(offs), .mode_i(mode), .xfer_done_i(done),
      .xfer_abort_i(abort), .rdata_i(rdata), .acc_valid_o(acc_valid),
      .acc_addr_o(acc_addr), .acc_byte_o(acc_byte), .acc_load_o(acc_load),
      .xlate_o(xlate), .unpred_o(unpred), .undef_o(undef), .bkpt_o(bkpt),
      .wb_en_o(wb_en), .wb_val_o(wb_val), .ld_valid_o(ld_valid),
      .ld_data_o(ld_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] f_sum(input logic [31:0] ins,
                                          input logic [DW-1:0] b, input logic [DW-1:0] o);
      return ins[23] ? (b + o) : (b - o);
   endfunction

   function automatic bit f_unpred(input logic [31:0] ins);
      bit wbf;
      wbf = !ins[24] || ins[21];
      return wbf && (ins[19:16] == ins[3:0] || ins[19:16] == ins[15:12]
                     || ins[19:16] == 4'd15 || ins[3:0] == 4'd15);
   endfunction

   task automatic op(input logic [31:0] ins, input logic [DW-1:0] b,
                     input logic [DW-1:0] o, input logic [4:0] md,
                     input bit ab, input logic [DW-1:0] rd);
      bit in_cls, b4, bk, wbreq, forced;
      logic [DW-1:0] s, a, ld_exp;
      in_cls = (ins[27:25] == 3'b011);
      b4     = ins[4];
      bk     = in_cls && b4 && ins[27:20] == 8'h7F && ins[19:0] == 20'hFDEFE;
      s      = f_sum(ins, b, o);
      a      = ins[24] ? s : b;
      wbreq  = !ins[24] || ins[21];
      forced = !ins[24] && ins[21];
      @(negedge clk);
      instr = ins; base = b; offs = o; mode = md; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (!in_cls) begin
         chk(acc_valid == 0 && undef == 0 && bkpt == 0, "R1 out-of-class ignored",
             {acc_valid, undef, bkpt}, 0);
      end else if (b4) begin
         chk(acc_valid == 0, "R2 no access on trap", acc_valid, 0);
         chk(undef == !bk, "R2 undef flag", undef, !bk);
         chk(bkpt == bk, "R3 breakpoint flag", bkpt, bk);
      end else begin
         chk(acc_valid == 1, "R8 issue pulse", acc_valid, 1);
         chk(acc_addr == a, "R4 address", acc_addr, a);
         chk(acc_byte == ins[22] && acc_load == ins[20], "R8 size/dir",
             {acc_byte, acc_load}, {ins[22], ins[20]});
         chk(unpred == f_unpred(ins), "R10 unpredictable", unpred, f_unpred(ins));
         chk(xlate == (forced ? 1'b0 : |md[1:0]), "R6 translate during xfer",
             xlate, forced ? 1'b0 : |md[1:0]);
         done = 1'b1; abort = ab; rdata = rd;
         @(negedge clk);
         done = 1'b0; abort = 1'b0;
         chk(wb_en == (wbreq && !ab), "R7 write-back enable", wb_en, wbreq && !ab);
         if (wbreq && !ab) chk(wb_val == s, "R5 write-back value", wb_val, s);
         chk(ld_valid == (ins[20] && !ab), "R9 load valid", ld_valid, ins[20] && !ab);
         ld_exp = ins[22] ? {24'h0, rd[7:0]} : rd;
         if (ins[20] && !ab) chk(ld_data == ld_exp, "R9 load data", ld_data, ld_exp);
         chk(xlate == |md[1:0], "R6 translate restored", xlate, |md[1:0]);
         @(negedge clk);
         chk(wb_en == 0, "R7 single-cycle write-back", wb_en, 0);
      end
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk(acc_valid == 0 && wb_en == 0 && undef == 0 && bkpt == 0 && ld_valid == 0,
          "R8 reset state", {acc_valid, wb_en, undef, bkpt}, 0);
      rst_n = 1'b1;
      // pre, add, W, word load, address wraps
      op(32'hE7B12003, 32'hFFFF_FFF0, 32'h20, 5'h13, 0, 32'h1234_5678);
      // pre, sub, no W: no write-back
      op(32'hE7112003, 32'h1000, 32'h10, 5'h10, 0, 32'h0);
      // post, sub, W: forced translate low
      op(32'hE6212003, 32'h2000, 32'h4, 5'h1F, 0, 32'h0);
      // post, add, byte load: zero extension
      op(32'hE6D12003, 32'h3000, 32'h1, 5'h11, 0, 32'hA5A5_A5C3);
      // aborted transfer with write-back form
      op(32'hE7B12003, 32'h4000, 32'h8, 5'h13, 1, 32'h0);
      // undefined (bit 4 set)
      op(32'hE7912013, 32'h0, 32'h0, 5'h10, 0, 32'h0);
      // breakpoint encoding
      op(32'hE7FFDEFE, 32'h0, 32'h0, 5'h10, 0, 32'h0);
      // class 0x7F with bit 4 but other payload: undefined
      op(32'hE7FFDEFF & 32'hFFFF_FFF0 | 32'h10, 32'h0, 32'h0, 5'h10, 0, 32'h0);
      // base is register 15 on a write-back form
      op(32'hE7AF2003, 32'h5000, 32'h4, 5'h10, 0, 32'h0);
      // out of class
      op(32'hE5912000, 32'h0, 32'h0, 5'h10, 0, 32'h0);
      // strobe while busy is ignored (R8)
      @(negedge clk);
      instr = 32'hE7912003; base = 32'h100; offs = 32'h4; req_valid = 1'b1;
      @(negedge clk);
      instr = 32'hE7912003; base = 32'h900; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(acc_valid == 0 && acc_addr == 32'h104, "R8 busy strobe ignored",
          acc_addr, 32'h104);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      repeat (2) @(negedge clk);
      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ins;
         ins = $urandom;
         ins[27:25] = 3'b011;
         if (($urandom % 8) != 0) ins[4] = 1'b0;
         op(ins, $urandom, $urandom, 5'($urandom), ($urandom % 4) == 0, $urandom);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule